// File: doc/BRIEF.md
# Message-Signalled Interrupt Vector Table Controller

This block keeps a table of message-signalled interrupt vectors for a device. Each vector has a 64-bit target address, a 32-bit payload and a per-vector mask. The block also keeps a read-only array of pending flags, one per vector. Software reaches both through a 4 KB window of 32-bit registers. A separate control byte holds the function enable bit and the function-wide mask bit. Device logic raises events by vector number. For each event the block either emits a memory-write request (address, payload, valid/ready handshake) or, when the vector is masked, records a pending flag so the message can be sent later.

Device logic also declares which vectors are in use by moving a small use counter for each vector up and down. Events for a vector whose counter is zero are dropped. A held message is replayed when software clears the mask that held it. This can be the entry's own mask bit, through a table write, or the function mask, through a control write with the enable bit set. If several replays become due together, they leave in ascending vector order, one message per accepted handshake.

Top module: `msix_ctrl_top`

## Requirements
- R1: Entry v of the table lives at byte offset 16*v. Within the entry, word 0 is the address low half, word 1 the address high half, word 2 the payload, and word 3 the control word, whose bit 0 is the vector mask and whose other bits read as zero. Read data appears on `reg_rdata` one cycle after `reg_rd`.
- R2: Only accesses with `reg_dword` high take effect. A narrow write changes nothing, and a narrow read returns zero. Address bits 1:0 are ignored.
- R3: The pending array sits at offset 0x800, with bit v of that word being vector v. It is read-only. Every other offset from 0x800 upward reads zero. Entries at or above the implemented count NVEC read zero and ignore writes.
- R4: Reset clears every address, payload, pending flag and use counter. It also clears both control bits, sets the mask bit of every implemented vector, and removes any message in flight.
- R5: An event for an unmasked vector with a nonzero use count produces one message carrying that entry's address and payload.
- R6: A vector counts as masked when its own mask bit or the function mask is set. An event for a masked vector sets its pending flag and produces no message.
- R7: A table write that leaves a pending vector unmasked clears its pending flag and sends its message.
- R8: A write to the control byte (bit 0 enable, bit 1 function mask) pulses `intx_clr` for one cycle, on the cycle after the write, only if the written enable bit is 1. With enable set and the function mask clear, every pending, unmasked vector is replayed. With enable clear, nothing is replayed.
- R9: Events for a vector number at or above NVEC, or for a vector whose use count is zero, are discarded.
- R10: When a vector's use count drops to zero, its pending flag is cleared, and that message is never sent.
- R11: While `msg_valid` is high and `msg_ready` is low, the message is held unchanged. When several messages are due at once, they leave in ascending vector order.
- R12: An event that arrives while a replay is stalled is queued and sent later, not lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register window write strobe |
| reg_rd | input | 1 | Register window read strobe |
| reg_dword | input | 1 | Access is a full 32-bit access |
| reg_addr | input | 12 | Byte offset in the window |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after the read strobe |
| ctl_wr | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte value: bit 0 enable, bit 1 function mask |
| ctl_rdata | output | 8 | Current control byte |
| intx_clr | output | 1 | One-cycle request to drop the legacy wire interrupt |
| trig_valid | input | 1 | Event strobe |
| trig_vec | input | 5 | Event vector number |
| use_valid | input | 1 | Use counter update strobe |
| use_up | input | 1 | 1 increments the counter, 0 decrements it |
| use_vec | input | 5 | Vector whose counter moves |
| msg_valid | output | 1 | Message write request valid |
| msg_ready | input | 1 | Message write request accepted |
| msg_addr | output | 64 | Message target address |
| msg_data | output | 32 | Message payload |

## Verification
The checker watches, on every cycle, the properties that involve only a few signals:
- a stalled message stays stable;
- narrow reads return zero;
- mask bits move only on full writes;
- `intx_clr` follows an enabling control write;
- the state right after reset is correct.

Some behaviours depend on a history of events and can only be shown by the bench's scenarios:
- whether a message is held or sent;
- the order of replays after unmasking;
- dropping of events for unused or unimplemented vectors;
- clearing of pending flags when a use count reaches zero;
- survival of an event that arrives during a stalled replay.

// File: rtl/msix_pkg.sv
package msix_pkg;
  localparam int unsigned WIN_AW    = 12;
  localparam int unsigned VIDX_W    = 5;
  localparam int unsigned DW        = 32;
  localparam int unsigned CTL_EN    = 0;
  localparam int unsigned CTL_FMASK = 1;

  typedef enum logic [1:0] {
    W_ADDR_LO = 2'd0,
    W_ADDR_HI = 2'd1,
    W_DATA    = 2'd2,
    W_CTRL    = 2'd3
  } entry_word_e;
endpackage

// File: rtl/msix_vec_table.sv
module msix_vec_table
  import msix_pkg::*;
#(
  parameter int unsigned NVEC = 32,
  localparam int unsigned VW  = (NVEC > 1) ? $clog2(NVEC) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic              reg_dword,
  input  logic [WIN_AW-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic              ctl_wr,
  input  logic [7:0]        ctl_wdata,
  output logic [7:0]        ctl_rdata,
  output logic              intx_clr,
  output logic              fn_mask,
  output logic              ctl_recheck,
  input  logic [NVEC-1:0]   pend,
  output logic [NVEC-1:0]   vmask,
  output logic              tbl_recheck_vld,
  output logic [VW-1:0]     tbl_recheck_vec,
  input  logic [VW-1:0]     sel_vec,
  output logic [63:0]       sel_addr,
  output logic [DW-1:0]     sel_data
);
  localparam logic [6:0] NVEC7 = 7'(NVEC);

  logic [DW-1:0]   addr_lo_q [NVEC];
  logic [DW-1:0]   addr_hi_q [NVEC];
  logic [DW-1:0]   data_q    [NVEC];
  logic [NVEC-1:0] vmask_q;
  logic            en_q, fmask_q;

  logic            in_table, ent_ok, pba_word0;
  logic [6:0]      ent;
  logic [VW-1:0]   ent_v;
  entry_word_e     wsel;
  logic [DW-1:0]   rd_word;

  assign in_table  = !reg_addr[11];
  assign ent       = reg_addr[10:4];
  assign ent_ok    = in_table && (ent < NVEC7);
  assign ent_v     = ent[VW-1:0];
  assign wsel      = entry_word_e'(reg_addr[3:2]);
  assign pba_word0 = reg_addr[11] && (reg_addr[10:2] == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NVEC; i++) begin
        addr_lo_q[i] <= '0;
        addr_hi_q[i] <= '0;
        data_q[i]    <= '0;
      end
      vmask_q         <= '1;
      tbl_recheck_vld <= 1'b0;
      tbl_recheck_vec <= '0;
    end else begin
      tbl_recheck_vld <= 1'b0;
      if (reg_wr && reg_dword && ent_ok) begin
        unique case (wsel)
          W_ADDR_LO: addr_lo_q[ent_v] <= reg_wdata;
          W_ADDR_HI: addr_hi_q[ent_v] <= reg_wdata;
          W_DATA:    data_q[ent_v]    <= reg_wdata;
          W_CTRL:    vmask_q[ent_v]   <= reg_wdata[0];
        endcase
        tbl_recheck_vld <= 1'b1;
        tbl_recheck_vec <= ent_v;
      end
    end
  end

  always_comb begin
    rd_word = '0;
    if (ent_ok) begin
      unique case (wsel)
        W_ADDR_LO: rd_word = addr_lo_q[ent_v];
        W_ADDR_HI: rd_word = addr_hi_q[ent_v];
        W_DATA:    rd_word = data_q[ent_v];
        W_CTRL:    rd_word = {{(DW-1){1'b0}}, vmask_q[ent_v]};
      endcase
    end else if (pba_word0) begin
      rd_word = DW'(pend);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= reg_dword ? rd_word : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q        <= 1'b0;
      fmask_q     <= 1'b0;
      intx_clr    <= 1'b0;
      ctl_recheck <= 1'b0;
    end else begin
      intx_clr    <= 1'b0;
      ctl_recheck <= 1'b0;
      if (ctl_wr) begin
        en_q        <= ctl_wdata[CTL_EN];
        fmask_q     <= ctl_wdata[CTL_FMASK];
        intx_clr    <= ctl_wdata[CTL_EN];
        ctl_recheck <= ctl_wdata[CTL_EN] && !ctl_wdata[CTL_FMASK];
      end
    end
  end

  assign ctl_rdata = {6'b0, fmask_q, en_q};
  assign fn_mask   = fmask_q;
  assign vmask     = vmask_q;
  assign sel_addr  = {addr_hi_q[sel_vec], addr_lo_q[sel_vec]};
  assign sel_data  = data_q[sel_vec];
endmodule

// File: rtl/msix_pend_track.sv
module msix_pend_track
  import msix_pkg::*;
#(
  parameter int unsigned NVEC  = 32,
  parameter int unsigned USE_W = 4,
  localparam int unsigned VW   = (NVEC > 1) ? $clog2(NVEC) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trig_valid,
  input  logic [VIDX_W-1:0] trig_vec,
  input  logic              use_valid,
  input  logic              use_up,
  input  logic [VIDX_W-1:0] use_vec,
  input  logic [NVEC-1:0]   vmask,
  input  logic              fn_mask,
  input  logic              tbl_recheck_vld,
  input  logic [VW-1:0]     tbl_recheck_vec,
  input  logic              ctl_recheck,
  input  logic              take_vld,
  input  logic [VW-1:0]     take_vec,
  output logic [NVEC-1:0]   pend,
  output logic [NVEC-1:0]   sendable
);
  localparam logic [USE_W-1:0] CNT_MAX = '1;

  logic [NVEC-1:0] pend_q, req_q, pend_n, req_n, move;
  logic [NVEC-1:0] masked, trig_oh, take_oh, rchk_oh, drop_oh;

  assign masked = vmask | {NVEC{fn_mask}};

  for (genvar v = 0; v < NVEC; v++) begin : g_vec
    logic [USE_W-1:0] cnt_q;
    logic             use_hit;

    assign use_hit    = use_valid && (use_vec == VIDX_W'(v));
    assign trig_oh[v] = trig_valid && (trig_vec == VIDX_W'(v)) && (cnt_q != '0);
    assign take_oh[v] = take_vld && (take_vec == VW'(v));
    assign rchk_oh[v] = ctl_recheck || (tbl_recheck_vld && tbl_recheck_vec == VW'(v));
    assign drop_oh[v] = use_hit && !use_up && (cnt_q == USE_W'(1));

    always_ff @(posedge clk) begin
      if (rst) begin
        cnt_q <= '0;
      end else if (use_hit) begin
        if (use_up && cnt_q != CNT_MAX)   cnt_q <= cnt_q + 1'b1;
        else if (!use_up && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  always_comb begin
    req_n  = req_q & ~take_oh;
    pend_n = pend_q | (req_n & masked);
    req_n  = req_n & ~masked;
    move   = pend_n & ~masked & rchk_oh;
    pend_n = pend_n & ~move;
    req_n  = req_n | move;
    pend_n = pend_n | (trig_oh & masked);
    req_n  = req_n | (trig_oh & ~masked);
    pend_n = pend_n & ~drop_oh;
    req_n  = req_n & ~drop_oh;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      req_q  <= '0;
    end else begin
      pend_q <= pend_n;
      req_q  <= req_n;
    end
  end

  assign pend     = pend_q;
  assign sendable = req_q & ~masked;
endmodule

// File: rtl/msix_msg_send.sv
module msix_msg_send
  import msix_pkg::*;
#(
  parameter int unsigned NVEC = 32,
  localparam int unsigned VW  = (NVEC > 1) ? $clog2(NVEC) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NVEC-1:0] sendable,
  output logic            take_vld,
  output logic [VW-1:0]   take_vec,
  input  logic [63:0]     sel_addr,
  input  logic [DW-1:0]   sel_data,
  output logic            msg_valid,
  input  logic            msg_ready,
  output logic [63:0]     msg_addr,
  output logic [DW-1:0]   msg_data
);
  logic          pick_vld, load;
  logic [VW-1:0] pick_vec;

  always_comb begin
    pick_vld = 1'b0;
    pick_vec = '0;
    for (int i = NVEC - 1; i >= 0; i--) begin
      if (sendable[i]) begin
        pick_vld = 1'b1;
        pick_vec = VW'(i);
      end
    end
  end

  assign load     = !msg_valid || msg_ready;
  assign take_vld = load && pick_vld;
  assign take_vec = pick_vec;

  always_ff @(posedge clk) begin
    if (rst) begin
      msg_valid <= 1'b0;
      msg_addr  <= '0;
      msg_data  <= '0;
    end else if (load) begin
      msg_valid <= pick_vld;
      if (pick_vld) begin
        msg_addr <= sel_addr;
        msg_data <= sel_data;
      end
    end
  end
endmodule

// File: rtl/msix_ctrl_top.sv
module msix_ctrl_top
  import msix_pkg::*;
#(
  parameter int unsigned NVEC  = 32,
  parameter int unsigned USE_W = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic        reg_dword,
  input  logic [11:0] reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        ctl_wr,
  input  logic [7:0]  ctl_wdata,
  output logic [7:0]  ctl_rdata,
  output logic        intx_clr,
  input  logic        trig_valid,
  input  logic [4:0]  trig_vec,
  input  logic        use_valid,
  input  logic        use_up,
  input  logic [4:0]  use_vec,
  output logic        msg_valid,
  input  logic        msg_ready,
  output logic [63:0] msg_addr,
  output logic [31:0] msg_data
);
  localparam int unsigned VW = (NVEC > 1) ? $clog2(NVEC) : 1;

  logic [NVEC-1:0] pend_w, vmask_w, sendable_w;
  logic            fn_mask_w, ctl_recheck_w, tbl_rchk_vld_w, take_vld_w;
  logic [VW-1:0]   tbl_rchk_vec_w, take_vec_w;
  logic [63:0]     sel_addr_w;
  logic [31:0]     sel_data_w;

  msix_vec_table #(.NVEC(NVEC)) table_i (
    .clk(clk), .rst(rst),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_dword(reg_dword),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .intx_clr(intx_clr), .fn_mask(fn_mask_w), .ctl_recheck(ctl_recheck_w),
    .pend(pend_w), .vmask(vmask_w),
    .tbl_recheck_vld(tbl_rchk_vld_w), .tbl_recheck_vec(tbl_rchk_vec_w),
    .sel_vec(take_vec_w), .sel_addr(sel_addr_w), .sel_data(sel_data_w)
  );

  msix_pend_track #(.NVEC(NVEC), .USE_W(USE_W)) track_i (
    .clk(clk), .rst(rst),
    .trig_valid(trig_valid), .trig_vec(trig_vec),
    .use_valid(use_valid), .use_up(use_up), .use_vec(use_vec),
    .vmask(vmask_w), .fn_mask(fn_mask_w),
    .tbl_recheck_vld(tbl_rchk_vld_w), .tbl_recheck_vec(tbl_rchk_vec_w),
    .ctl_recheck(ctl_recheck_w),
    .take_vld(take_vld_w), .take_vec(take_vec_w),
    .pend(pend_w), .sendable(sendable_w)
  );

  msix_msg_send #(.NVEC(NVEC)) send_i (
    .clk(clk), .rst(rst),
    .sendable(sendable_w), .take_vld(take_vld_w), .take_vec(take_vec_w),
    .sel_addr(sel_addr_w), .sel_data(sel_data_w),
    .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_addr(msg_addr), .msg_data(msg_data)
  );
endmodule

// File: rtl/msix_ctrl_chk.sv
module msix_ctrl_chk #(
  parameter int unsigned NVEC = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            reg_wr,
  input logic            reg_rd,
  input logic            reg_dword,
  input logic [31:0]     reg_rdata,
  input logic            ctl_wr,
  input logic [7:0]      ctl_wdata,
  input logic [7:0]      ctl_rdata,
  input logic            intx_clr,
  input logic            msg_valid,
  input logic            msg_ready,
  input logic [63:0]     msg_addr,
  input logic [31:0]     msg_data,
  input logic [NVEC-1:0] pend_w,
  input logic [NVEC-1:0] vmask_w
);
  // R11
  msg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_addr) && $stable(msg_data));

  // R4
  rst_state_chk: assert property (@(posedge clk)
    rst |=> !msg_valid && ctl_rdata == 8'h00 && pend_w == '0 && vmask_w == '1);

  // R2
  narrow_rd_chk: assert property (@(posedge clk) disable iff (rst)
    reg_rd && !reg_dword |=> reg_rdata == 32'h0);

  // R2
  mask_only_full_wr_chk: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr && reg_dword) |=> $stable(vmask_w));

  // R8
  intx_after_ctl_chk: assert property (@(posedge clk) disable iff (rst)
    intx_clr |-> $past(ctl_wr) && $past(ctl_wdata[0]));
endmodule

bind msix_ctrl_top msix_ctrl_chk #(.NVEC(NVEC)) chk_i (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_dword(reg_dword),
  .reg_rdata(reg_rdata), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
  .ctl_rdata(ctl_rdata), .intx_clr(intx_clr), .msg_valid(msg_valid),
  .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data),
  .pend_w(pend_w), .vmask_w(vmask_w)
);

// File: tb/msix_ctrl_top_tb_top.sv
module msix_ctrl_top_tb_top;
  localparam int NV  = 6;
  localparam int NT  = 12;
  localparam time HP = 10ns;

  logic        clk = 1'b0, rst = 1'b1;
  logic        reg_wr = 0, reg_rd = 0, reg_dword = 0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        ctl_wr = 0;
  logic [7:0]  ctl_wdata = '0, ctl_rdata;
  logic        intx_clr;
  logic        trig_valid = 0;
  logic [4:0]  trig_vec = '0;
  logic        use_valid = 0, use_up = 0;
  logic [4:0]  use_vec = '0;
  logic        msg_valid, msg_ready = 1'b1;
  logic [63:0] msg_addr;
  logic [31:0] msg_data;

  int n_run = 0, n_fail = 0, msg_cnt = 0;
  bit done = 0;
  logic [31:0] log_d [32];
  logic [63:0] log_a [32];

  always #HP clk = ~clk;

  msix_ctrl_top #(.NVEC(NV), .USE_W(4)) dut_i (.*);

  // fields: req(4) waddr(12) wkind(2: 0 none,1 narrow,2 dword) wdata(32) raddr(12) rdword(1) exp(32)
  function automatic logic [94:0] mk(input logic [3:0] rq, input logic [11:0] wa,
      input logic [1:0] wk, input logic [31:0] wd, input logic [11:0] ra,
      input logic rdw, input logic [31:0] ex);
    return {rq, wa, wk, wd, ra, rdw, ex};
  endfunction

  localparam logic [94:0] VECS [NT] = '{
    mk(4'd1, 12'h010, 2'd2, 32'h1000_0040, 12'h010, 1'b1, 32'h1000_0040),
    mk(4'd1, 12'h014, 2'd2, 32'h0000_ABCD, 12'h014, 1'b1, 32'h0000_ABCD),
    mk(4'd1, 12'h018, 2'd2, 32'hDEAD_0001, 12'h018, 1'b1, 32'hDEAD_0001),
    mk(4'd1, 12'h01C, 2'd2, 32'hFFFF_FFFE, 12'h01C, 1'b1, 32'h0),
    mk(4'd2, 12'h01C, 2'd1, 32'h0000_0001, 12'h01C, 1'b1, 32'h0),
    mk(4'd2, 12'h018, 2'd2, 32'h0000_0055, 12'h018, 1'b0, 32'h0),
    mk(4'd2, 12'h023, 2'd2, 32'h1234_5678, 12'h020, 1'b1, 32'h1234_5678),
    mk(4'd3, 12'h060, 2'd2, 32'hCAFE_0000, 12'h060, 1'b1, 32'h0),
    mk(4'd3, 12'h800, 2'd2, 32'hFFFF_FFFF, 12'h800, 1'b1, 32'h0),
    mk(4'd4, 12'h000, 2'd0, 32'h0,         12'h02C, 1'b1, 32'h1),
    mk(4'd3, 12'h000, 2'd0, 32'h0,         12'h804, 1'b1, 32'h0),
    mk(4'd1, 12'h000, 2'd0, 32'h0,         12'h018, 1'b1, 32'h55)
  };

  always begin
    @(negedge clk); #1;
    if (!rst && msg_valid && msg_ready) begin
      if (msg_cnt < 32) begin
        log_d[msg_cnt] = msg_data;
        log_a[msg_cnt] = msg_addr;
      end
      msg_cnt++;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_write(input logic [11:0] a, input logic [31:0] d, input logic dw);
    @(negedge clk); reg_wr = 1; reg_dword = dw; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0; reg_dword = 0;
  endtask

  task automatic reg_read(input logic [11:0] a, input logic dw, output logic [31:0] d);
    @(negedge clk); reg_rd = 1; reg_dword = dw; reg_addr = a;
    @(negedge clk); reg_rd = 0; reg_dword = 0; d = reg_rdata;
  endtask

  task automatic ctl_write(input logic en, input logic fm, output logic intx);
    @(negedge clk); ctl_wr = 1; ctl_wdata = {6'b0, fm, en};
    @(negedge clk); ctl_wr = 0; intx = intx_clr;
  endtask

  task automatic trigger(input logic [4:0] v);
    @(negedge clk); trig_valid = 1; trig_vec = v;
    @(negedge clk); trig_valid = 0;
  endtask

  task automatic use_op(input logic [4:0] v, input logic up);
    @(negedge clk); use_valid = 1; use_up = up; use_vec = v;
    @(negedge clk); use_valid = 0;
  endtask

  task automatic wait_msgs(input int target);
    for (int k = 0; k < 40 && msg_cnt < target; k++) @(negedge clk);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    #(HP * 2 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL R11 watchdog expired actual=hung expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic ix;
    int base;
    idle(3);
    rst = 0;
    idle(1);
    // R4 state after reset
    chk(msg_valid == 0 && ctl_rdata == 0 && intx_clr == 0, "R4 reset outputs",
        {ctl_rdata, 7'b0, msg_valid}, 64'h0);

    for (int i = 0; i < NT; i++) begin
      logic [94:0] v;
      v = VECS[i];
      if (v[78:77] != 2'd0) reg_write(v[90:79], v[76:45], v[78:77] == 2'd2);
      reg_read(v[44:33], v[32], rd);
      if (rd != v[31:0]) $display("  vector %0d at R%0d", i, v[94:91]);
      chk(rd == v[31:0], "R1/R2/R3/R4 register vector", rd, v[31:0]);
    end

    // R9: zero use count drops the event
    base = msg_cnt;
    trigger(5'd1); idle(8);
    chk(msg_cnt == base, "R9 zero use count", msg_cnt, base);

    // R5: unmasked vector with use count sends
    use_op(5'd1, 1'b1);
    trigger(5'd1); wait_msgs(base + 1);
    chk(msg_cnt == base + 1, "R5 message count", msg_cnt, base + 1);
    chk(log_a[base] == 64'h0000ABCD_10000040, "R5 message address", log_a[base], 64'h0000ABCD_10000040);
    chk(log_d[base] == 32'h55, "R5 message payload", log_d[base], 32'h55);

    // R9: vector beyond implemented count
    base = msg_cnt;
    trigger(5'd6); idle(8);
    chk(msg_cnt == base, "R9 vector out of range", msg_cnt, base);

    // R6: own mask holds the event in the pending array
    reg_write(12'h020, 32'h0000_2000, 1'b1);
    reg_write(12'h024, 32'h0, 1'b1);
    reg_write(12'h028, 32'h22, 1'b1);
    use_op(5'd2, 1'b1);
    trigger(5'd2); idle(6);
    chk(msg_cnt == base, "R6 masked vector silent", msg_cnt, base);
    reg_read(12'h800, 1'b1, rd);
    chk(rd == 32'h4, "R6 pending bit 2", rd, 32'h4);

    // R7: unmasking the entry replays it
    reg_write(12'h02C, 32'h0, 1'b1);
    wait_msgs(base + 1);
    chk(msg_cnt == base + 1 && log_d[base] == 32'h22, "R7 replay on entry unmask", log_d[base], 32'h22);
    reg_read(12'h800, 1'b1, rd);
    chk(rd == 32'h0, "R7 pending cleared", rd, 32'h0);

    // R6 / R8: function mask, then enable-clear write, then enabling write
    ctl_write(1'b1, 1'b1, ix);
    chk(ix == 1'b1, "R8 intx pulse on enabling write", ix, 1);
    base = msg_cnt;
    trigger(5'd2); trigger(5'd1); idle(4);
    reg_read(12'h800, 1'b1, rd);
    chk(rd == 32'h6 && msg_cnt == base, "R6 function mask holds both", rd, 32'h6);
    ctl_write(1'b0, 1'b0, ix);
    chk(ix == 1'b0, "R8 no intx pulse when disabled", ix, 0);
    idle(8);
    reg_read(12'h800, 1'b1, rd);
    chk(rd == 32'h6 && msg_cnt == base, "R8 no replay when disabled", rd, 32'h6);
    ctl_write(1'b1, 1'b0, ix);
    wait_msgs(base + 2);
    chk(msg_cnt == base + 2, "R8 replay count", msg_cnt, base + 2);
    chk(log_d[base] == 32'h55 && log_d[base+1] == 32'h22, "R11 ascending replay order",
        {log_d[base], log_d[base+1]}, {32'h55, 32'h22});

    // R10: use count to zero clears the pending flag
    ctl_write(1'b1, 1'b1, ix);
    base = msg_cnt;
    trigger(5'd1); idle(3);
    reg_read(12'h800, 1'b1, rd);
    chk(rd == 32'h2, "R10 pending before release", rd, 32'h2);
    use_op(5'd1, 1'b0); idle(2);
    reg_read(12'h800, 1'b1, rd);
    chk(rd == 32'h0, "R10 pending cleared on zero count", rd, 32'h0);
    ctl_write(1'b1, 1'b0, ix); idle(8);
    chk(msg_cnt == base, "R10 nothing replayed", msg_cnt, base);

    // R11: back-pressure holds the message
    use_op(5'd1, 1'b1);
    msg_ready = 0;
    trigger(5'd2); trigger(5'd1); idle(4);
    chk(msg_valid == 1 && msg_data == 32'h22, "R11 stalled message", msg_data, 32'h22);
    idle(3);
    chk(msg_valid == 1 && msg_data == 32'h22, "R11 message held", msg_data, 32'h22);
    msg_ready = 1;
    wait_msgs(base + 2);
    chk(msg_cnt == base + 2 && log_d[base+1] == 32'h55, "R11 queued message follows",
        log_d[base+1], 32'h55);

    // R12: event during a stalled replay is kept
    ctl_write(1'b1, 1'b1, ix);
    base = msg_cnt;
    trigger(5'd1); trigger(5'd2);
    msg_ready = 0;
    ctl_write(1'b1, 1'b0, ix); idle(4);
    chk(msg_valid == 1 && msg_data == 32'h55, "R12 replay stalled", msg_data, 32'h55);
    trigger(5'd1); idle(2);
    msg_ready = 1;
    wait_msgs(base + 3);
    chk(msg_cnt == base + 3, "R12 all messages delivered", msg_cnt, base + 3);
    chk(log_d[base] == 32'h55 && log_d[base+1] == 32'h55 && log_d[base+2] == 32'h22,
        "R12 order with late event", {log_d[base+1], log_d[base+2]}, {32'h55, 32'h22});

    // R4: reset mid-run
    rst = 1; idle(2); rst = 0; idle(1);
    chk(msg_valid == 0 && ctl_rdata == 0, "R4 outputs after reset", {ctl_rdata, 7'b0, msg_valid}, 0);
    reg_read(12'h01C, 1'b1, rd);
    chk(rd == 32'h1, "R4 mask set after reset", rd, 32'h1);
    reg_read(12'h010, 1'b1, rd);
    chk(rd == 32'h0, "R4 address cleared", rd, 32'h0);
    reg_write(12'h01C, 32'h0, 1'b1);
    base = msg_cnt;
    trigger(5'd1); idle(6);
    reg_read(12'h800, 1'b1, rd);
    chk(msg_cnt == base && rd == 32'h0, "R4 use counts cleared", rd, 32'h0);

    done = 1;
    summary();
    $finish;
  end
endmodule